// File: doc/BRIEF.md
# Real-Time Clock Update Sequencer and Interrupt Flag Controller

This block paces the once-per-second update of a real-time clock and keeps its status and interrupt flags. It counts strobes from a 32.768 kHz tick source and emits a one-clock update strobe on every second boundary. Ahead of each update it raises an update-in-progress indication, which software polls before it reads the time.

It latches three event flags: update-ended, periodic and alarm. From these flags and their enable bits it drives an interrupt request. The alarm comparison, the periodic-rate divider and the time counters sit outside this block. They deliver `alarm_match` as a level and `periodic_tick` as a one-clock strobe.

A small host register port reaches three registers. A read-only status register carries the update-in-progress bit. A control register holds the update-inhibit bit and the three interrupt enables. The flag register clears itself when it is read.

Top module: `rtc_update_ctl`

## Requirements
- R1: `update_strobe` pulses high for exactly one clock after every TICKS_PER_SEC-th `tick` counted since the divider was last released. No strobe occurs at any other time.
- R2: `uip` is high once the divider has counted TICKS_PER_SEC-UIP_LEAD or more ticks in the current second. It stays high through the cycle in which `update_strobe` is high and is low otherwise, so a low `uip` means no update within the next UIP_LEAD ticks.
- R3: Reading address 0 returns `uip` in bit 7 and zeros in bits 6:0. Writes to address 0 have no effect.
- R4: Address 1 is the control register: bit 7 inhibit (SET), bit 6 periodic enable, bit 5 alarm enable, bit 4 update-ended enable. Bits 3:0 read as 0 and ignore writes.
- R5: While SET is 1, the divider holds at zero, `uip` stays low and no update occurs. After SET is cleared, the first update follows a full TICKS_PER_SEC ticks later.
- R6: The update-ended flag sets in the same cycle in which `update_strobe` goes high.
- R7: The alarm flag sets on the first `tick` after an update if `alarm_match` is high during that tick. If `alarm_match` is low then, the flag stays clear.
- R8: The periodic flag sets on every `periodic_tick` strobe.
- R9: Each flag sets regardless of its enable bit. `irq` is high exactly when at least one flag is set together with its matching enable bit.
- R10: Address 2 is the flag register: bit 7 IRQ pending, bit 6 periodic, bit 5 alarm, bit 4 update-ended, bits 3:0 zero. A read returns the current values and then clears all flags and `irq`. A flag event arriving in the same cycle as the read survives the read.
- R11: Reset clears all flags, `irq`, SET and the enables, and restarts the divider at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock strobe at 32.768 kHz |
| alarm_match | input | 1 | High while the time equals the alarm setting |
| periodic_tick | input | 1 | One-clock strobe from the periodic-rate divider |
| wr_en | input | 1 | Register write enable |
| rd_en | input | 1 | Register read enable; a read of address 2 clears the flags |
| addr | input | 2 | Register select: 0 status, 1 control, 2 flags |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, zero when `rd_en` is low |
| update_strobe | output | 1 | One-clock pulse at each second boundary |
| uip | output | 1 | Update-in-progress indication |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- the update strobe lasts a single cycle;
- `uip` is high in the cycle before each strobe and in the strobe cycle itself;
- no strobe appears while SET is held;
- the update-ended flag rises only with a strobe;
- `irq` stays low with all enables off;
- a flag read with no coinciding event leaves every flag and `irq` clear.

Some behaviours need exact counts and sequences, so only the directed scenarios can show them:
- the tick number at which `uip` rises and the tick on which the update lands;
- the one-tick lag of the alarm flag and its dependence on `alarm_match`;
- that a flag event survives a simultaneous read;
- that writes to the status register have no effect;
- that releasing SET restarts a full second.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_CTRL   = 2'd1,
        REG_FLAGS  = 2'd2
    } reg_sel_e;

    // one bit per event source; the same layout serves flags and enables
    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } evt_set_t;

    typedef struct packed {
        logic     inhibit;
        evt_set_t en;
    } ctrl_t;

endpackage

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_LEAD      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    output logic boundary,     // combinational: this edge is the update edge
    output logic upd_strobe,
    output logic alarm_slot,   // combinational: first tick after an update
    output logic uip
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST_CNT  = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] UIP_START = CW'(TICKS_PER_SEC - UIP_LEAD);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          upd;
        logic          af_wait;
    } div_st_t;

    div_st_t st_d, st_q;

    assign boundary   = tick && !hold && (st_q.cnt == LAST_CNT);
    assign alarm_slot = tick && !hold && st_q.af_wait;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (hold) begin
            st_d.cnt     = '0;
            st_d.af_wait = 1'b0;
        end else if (tick) begin
            if (st_q.cnt == LAST_CNT) begin
                st_d.cnt     = '0;
                st_d.upd     = 1'b1;
                st_d.af_wait = 1'b1;
            end else begin
                st_d.cnt     = st_q.cnt + 1'b1;
                st_d.af_wait = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upd_strobe = st_q.upd;
    assign uip        = (st_q.cnt >= UIP_START) || st_q.upd;

endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
    import rtc_upd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     upd_evt,
    input  logic     alarm_slot,
    input  logic     alarm_match,
    input  logic     periodic_tick,
    input  logic     clr,
    input  evt_set_t en,
    output evt_set_t flags,
    output logic     irq
);
    evt_set_t flags_d, flags_q;

    always_comb begin
        flags_d = clr ? '0 : flags_q;
        // set events take priority over the clear-on-read
        if (periodic_tick)              flags_d.pf = 1'b1;
        if (upd_evt)                    flags_d.uf = 1'b1;
        if (alarm_slot && alarm_match)  flags_d.af = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & en);

endmodule

// File: rtl/rtc_update_ctl.sv
module rtc_update_ctl
    import rtc_upd_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_LEAD      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       alarm_match,
    input  logic       periodic_tick,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       update_strobe,
    output logic       uip,
    output logic       irq
);
    ctrl_t    ctrl_d, ctrl_q;
    evt_set_t flags;
    logic     boundary;
    logic     alarm_slot;
    logic     flag_clr;

    assign flag_clr = rd_en && (reg_sel_e'(addr) == REG_FLAGS);

    rtc_sec_divider #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .UIP_LEAD      (UIP_LEAD)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .hold       (ctrl_q.inhibit),
        .boundary   (boundary),
        .upd_strobe (update_strobe),
        .alarm_slot (alarm_slot),
        .uip        (uip)
    );

    rtc_flag_unit u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .upd_evt       (boundary),
        .alarm_slot    (alarm_slot),
        .alarm_match   (alarm_match),
        .periodic_tick (periodic_tick),
        .clr           (flag_clr),
        .en            (ctrl_q.en),
        .flags         (flags),
        .irq           (irq)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && (reg_sel_e'(addr) == REG_CTRL)) begin
            ctrl_d.inhibit = wdata[7];
            ctrl_d.en.pf   = wdata[6];
            ctrl_d.en.af   = wdata[5];
            ctrl_d.en.uf   = wdata[4];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        rdata = 8'h00;
        if (rd_en) begin
            case (reg_sel_e'(addr))
                REG_STATUS: rdata = {uip, 7'b0};
                REG_CTRL:   rdata = {ctrl_q.inhibit, ctrl_q.en.pf, ctrl_q.en.af, ctrl_q.en.uf, 4'b0};
                REG_FLAGS:  rdata = {irq, flags.pf, flags.af, flags.uf, 4'b0};
                default:    rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/rtc_update_ctl_chk.sv
module rtc_update_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       periodic_tick,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic [7:0] rdata,
    input logic       update_strobe,
    input logic       uip,
    input logic       irq,
    input logic       inhibit,
    input logic [2:0] en,
    input logic [2:0] flags
);
    p_strobe_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        update_strobe |=> !update_strobe);

    p_uip_at_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
        update_strobe |-> (uip && $past(uip)));

    p_inhibit_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && $past(inhibit)) |-> !update_strobe);

    p_uf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> update_strobe);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 3'b000) |-> !irq);

    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd2 && !periodic_tick && !tick) |=> (flags == 3'b000 && !irq));

    p_irq_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd2) |-> (rdata[7] == irq));

endmodule

bind rtc_update_ctl rtc_update_ctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .periodic_tick (periodic_tick),
    .rd_en         (rd_en),
    .addr          (addr),
    .rdata         (rdata),
    .update_strobe (update_strobe),
    .uip           (uip),
    .irq           (irq),
    .inhibit       (ctrl_q.inhibit),
    .en            (ctrl_q.en),
    .flags         (flags)
);

// File: tb/rtc_update_ctl_test.sv
module rtc_update_ctl_test;
    localparam int TPS  = 64;
    localparam int LEAD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       alarm_match = 1'b0;
    logic       periodic_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       update_strobe;
    logic       uip;
    logic       irq;

    int vectors = 0;
    int miscompares = 0;
    int strobes = 0;
    logic [7:0] en_bits = 8'h00;   // enables kept by the bench, bits 6:4

    always #10 clk = ~clk;

    rtc_update_ctl #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_match(alarm_match),
        .periodic_tick(periodic_tick), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .update_strobe(update_strobe), .uip(uip), .irq(irq)
    );

    always @(negedge clk) if (rst_n && update_strobe) strobes++;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic restart_div();
        reg_wr(2'd1, 8'h80 | en_bits);
        reg_wr(2'd1, en_bits);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        reg_rd(2'd0, v); chk("R11 status after reset", v, 8'h00);
        reg_rd(2'd1, v); chk("R11 ctrl after reset", v, 8'h00);
        reg_rd(2'd2, v); chk("R11 flags after reset", v, 8'h00);
        chk("R11 irq after reset", irq, 0);
        chk("R1 no strobe after reset", update_strobe, 0);
    endtask

    task automatic t_uip_and_update();
        logic [7:0] v;
        int s0;
        restart_div();
        s0 = strobes;
        ticks(TPS - LEAD - 1);
        chk("R2 uip low before window", uip, 0);
        ticks(1);
        chk("R2 uip high at window start", uip, 1);
        reg_rd(2'd0, v); chk("R3 status shows uip", v, 8'h80);
        reg_wr(2'd0, 8'h00);
        reg_rd(2'd0, v); chk("R3 status write ignored", v, 8'h80);
        ticks(LEAD - 1);
        chk("R1 no strobe before boundary", strobes - s0, 0);
        chk("R2 uip still high", uip, 1);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R1 strobe on boundary", update_strobe, 1);
        chk("R2 uip during strobe", uip, 1);
        @(negedge clk);
        chk("R1 strobe one cycle", update_strobe, 0);
        chk("R2 uip low after update", uip, 0);
        repeat (2) @(negedge clk);
        chk("R9 irq masked", irq, 0);
        reg_rd(2'd2, v); chk("R6 uf set by update", v, 8'h10);
        chk("R1 single strobe per second", strobes - s0, 1);
    endtask

    task automatic t_alarm();
        logic [7:0] v;
        en_bits = 8'h20;
        restart_div();
        alarm_match = 1'b1;
        ticks(TPS);
        chk("R7 no af before next tick", irq, 0);
        ticks(1);
        chk("R7 af raises irq after one tick", irq, 1);
        reg_rd(2'd2, v); chk("R10 flag read af+uf+irq", v, 8'hB0);
        chk("R10 irq cleared by read", irq, 0);
        reg_rd(2'd2, v); chk("R10 flags cleared by read", v, 8'h00);
        alarm_match = 1'b0;
        restart_div();
        ticks(TPS + 1);
        alarm_match = 1'b1;
        ticks(2);
        reg_rd(2'd2, v); chk("R7 no af without match", v, 8'h10);
        alarm_match = 1'b0;
    endtask

    task automatic t_periodic();
        logic [7:0] v;
        en_bits = 8'h00;
        reg_wr(2'd1, en_bits);
        periodic_tick = 1'b1;
        @(negedge clk);
        periodic_tick = 1'b0;
        chk("R9 pf set but irq masked", irq, 0);
        en_bits = 8'h40;
        reg_wr(2'd1, en_bits);
        chk("R9 irq with pie", irq, 1);
        reg_rd(2'd2, v); chk("R8 pf flag read", v, 8'hC0);
        chk("R10 irq clear after read", irq, 0);
        en_bits = 8'h00;
        reg_wr(2'd1, en_bits);
        periodic_tick = 1'b1;
        @(negedge clk);
        addr = 2'd2; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; periodic_tick = 1'b0;
        chk("R10 read value before event", v, 8'h40);
        reg_rd(2'd2, v); chk("R10 event survives read", v, 8'h40);
    endtask

    task automatic t_inhibit();
        logic [7:0] v;
        int s0;
        reg_wr(2'd1, 8'h7F);
        reg_rd(2'd1, v); chk("R4 ctrl low bits zero", v, 8'h70);
        reg_wr(2'd1, 8'h80);
        reg_rd(2'd1, v); chk("R4 ctrl set bit", v, 8'h80);
        s0 = strobes;
        ticks(TPS + 6);
        chk("R5 no update while set", strobes - s0, 0);
        chk("R5 uip low while set", uip, 0);
        reg_wr(2'd1, 8'h00);
        ticks(TPS - 1);
        chk("R5 full second after release", strobes - s0, 0);
        ticks(1);
        chk("R5 update after release", strobes - s0, 1);
        reg_rd(2'd2, v);
    endtask

    task automatic t_reset_again();
        logic [7:0] v;
        reg_wr(2'd1, 8'hF0);
        periodic_tick = 1'b1;
        @(negedge clk);
        periodic_tick = 1'b0;
        chk("R9 irq before reset", irq, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R11 irq cleared by reset", irq, 0);
        reg_rd(2'd1, v); chk("R11 ctrl cleared by reset", v, 8'h00);
        reg_rd(2'd2, v); chk("R11 flags cleared by reset", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uip_and_update();
        t_alarm();
        t_periodic();
        t_inhibit();
        t_reset_again();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule